// File: doc/BRIEF.md
# 64-bit Compare Timer with Periodic Reload

This block keeps a free-running 64-bit up-counter and a 64-bit compare value behind a small 32-bit register bus. When the counter reaches or passes the compare value, a sticky event flag is set. An interrupt output follows that flag, but only while interrupts are enabled. With auto-increment set, each match adds a programmable 32-bit step to the compare value. Software therefore gets a regular tick without rewriting the compare registers after every event.

The counter advances on the single block clock. An 8-bit divider in the control word slows it to one count every `divide + 1` clocks. Software reads the counter as two live halves, and neither read latches the other half. A coherent 64-bit read is upper, lower, upper again, with a retry whenever the two upper reads differ. The compare value should be changed only while compare is disabled: clear the enable, write both halves, then set the enable again.

The register port is a plain single-cycle bus. A write happens on any clock edge where `bus_valid` and `bus_we` are both high. `bus_rdata` is combinational from `bus_word` at all times. The port has no back-pressure: every access completes in the cycle it is presented.

Top module: `cmp_timer64`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low. Word offsets: 0 counter low, 1 counter high, 2 control, 3 status, 4 compare low, 5 compare high, 6 step.
- R2: While control bit 0 (run) is set, the counter goes up by one once every `div + 1` clocks, where `div` is control bits 15:8. While run is clear, the counter holds its value.
- R3: Words 0 and 1 each return the live 32-bit half of the counter. A carry out of the low half appears in the high half in the same clock.
- R4: A write to word 0 or word 1 loads that counter half only while run is clear. While run is set, such a write is ignored.
- R5: In any clock where run and compare enable (control bit 1) are both set and the counter is at or above the compare value, status bit 0 is set at the next edge.
- R6: Writing a 1 to status bit 0 clears it, unless a match occurs in the same clock, in which case the bit stays set. Writing a 0 has no effect.
- R7: `irq_o` is high exactly when status bit 0 and interrupt enable (control bit 2) are both set.
- R8: When a match occurs with auto-increment (control bit 3) set and no compare write in that clock, the compare value grows by the step register.
- R9: Compare halves (words 4 and 5) take bus writes at any time. Without auto-increment, the compare value never changes except through such writes.
- R10: Control stores only bits 3:0 and 15:8. All other bits read back as zero.
- R11: Word 7 reads zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_word | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_word`, combinational |
| irq_o | output | 1 | Interrupt: event flag gated by interrupt enable |

## Verification
The assertions assume that reset is held low from time zero until the first useful clock. They also assume that any clock may carry a register write, so they exclude write cycles wherever a write legitimately overrides counting or reloading. The stimulus changes inputs only well away from the rising edge and issues one access at a time. It follows the documented disable-then-rewrite order for the compare halves, except in one deliberate case that checks that writes are always accepted. It also drives the low half near its wrap point, so that the carry into the high half is exercised.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int unsigned WORD_IDX_W = 3;

  typedef enum logic [WORD_IDX_W-1:0] {
    W_CNT_LO = 3'd0,
    W_CNT_HI = 3'd1,
    W_CTRL   = 3'd2,
    W_STAT   = 3'd3,
    W_CMP_LO = 3'd4,
    W_CMP_HI = 3'd5,
    W_STEP   = 3'd6,
    W_NONE   = 3'd7
  } word_e;

  typedef struct packed {
    logic [7:0] div;
    logic       auto_inc;
    logic       irq_en;
    logic       cmp_en;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] phase_q;

  assign tick = run && (phase_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase_q <= '0;
    else if (!run)   phase_q <= '0;
    else if (tick)   phase_q <= '0;
    else             phase_q <= phase_q + 1'b1;
  end

  // R2: with a nonzero divider, ticks never land on back-to-back clocks
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || limit == '0));
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int unsigned HALF_W = 32,
  parameter int unsigned NHALF  = 2,
  localparam int unsigned CNT_W = HALF_W * NHALF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic [NHALF-1:0]  wr_half,
  input  logic [HALF_W-1:0] wdata,
  output logic [CNT_W-1:0]  count
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      for (int h = 0; h < int'(NHALF); h++) begin
        if (wr_half[h]) cnt_q[h*HALF_W +: HALF_W] <= wdata;
      end
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count = cnt_q;

  // R2: a running counter without a tick keeps its value
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> count == $past(count));
  // R2, R4: a running counter moves by exactly one per tick, whatever the bus does
  p_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick) |=> count == $past(count) + 1'b1);
  // R2: a stopped counter with no write holds
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && wr_half == '0) |=> $stable(count));
endmodule

// File: rtl/cmt_compare.sv
module cmt_compare #(
  parameter int unsigned HALF_W = 32,
  parameter int unsigned NHALF  = 2,
  localparam int unsigned CNT_W = HALF_W * NHALF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              auto_inc,
  input  logic [CNT_W-1:0]  count,
  input  logic [HALF_W-1:0] step,
  input  logic [NHALF-1:0]  wr_half,
  input  logic [HALF_W-1:0] wdata,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              hit
);
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] step_ext;

  assign step_ext = {{(CNT_W-HALF_W){1'b0}}, step};
  assign hit      = active && (count >= cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (wr_half != '0) begin
      for (int h = 0; h < int'(NHALF); h++) begin
        if (wr_half[h]) cmp_q[h*HALF_W +: HALF_W] <= wdata;
      end
    end else if (hit && auto_inc) begin
      cmp_q <= cmp_q + step_ext;
    end
  end

  assign cmp_val = cmp_q;

  // R8: an auto-increment match moves the compare value up by one step
  p_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && auto_inc && wr_half == '0) |=> cmp_val == $past(cmp_val) + $past(step_ext));
  // R9: with no reload and no write the compare value is frozen
  p_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(hit && auto_inc) && wr_half == '0) |=> $stable(cmp_val));
endmodule

// File: rtl/cmp_timer64.sv
module cmp_timer64 #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIV_W  = 8,
  localparam int unsigned NHALF = 2,
  localparam int unsigned CNT_W = DATA_W * NHALF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [2:0]        bus_word,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  import cmt_pkg::*;

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] step_q;
  logic              event_q;
  logic              wr;
  logic [NHALF-1:0]  cnt_wr, cmp_wr;
  logic              tick, hit;
  logic [CNT_W-1:0]  count, cmp_val;
  word_e             widx;

  assign widx   = word_e'(bus_word);
  assign wr     = bus_valid && bus_we;
  assign cnt_wr = {wr && widx == W_CNT_HI, wr && widx == W_CNT_LO};
  assign cmp_wr = {wr && widx == W_CMP_HI, wr && widx == W_CMP_LO};

  cmt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .limit(ctrl_q.div), .tick(tick)
  );

  cmt_counter #(.HALF_W(DATA_W), .NHALF(NHALF)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .tick(tick),
    .wr_half(cnt_wr), .wdata(bus_wdata), .count(count)
  );

  cmt_compare #(.HALF_W(DATA_W), .NHALF(NHALF)) u_cmp (
    .clk(clk), .rst_n(rst_n), .active(ctrl_q.run && ctrl_q.cmp_en),
    .auto_inc(ctrl_q.auto_inc), .count(count), .step(step_q),
    .wr_half(cmp_wr), .wdata(bus_wdata), .cmp_val(cmp_val), .hit(hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      step_q <= '0;
    end else if (wr) begin
      if (widx == W_CTRL) ctrl_q <= ctrl_t'({bus_wdata[8+DIV_W-1:8], bus_wdata[3:0]});
      if (widx == W_STEP) step_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     event_q <= 1'b0;
    else if (hit)                                   event_q <= 1'b1;
    else if (wr && widx == W_STAT && bus_wdata[0])  event_q <= 1'b0;
  end

  assign irq_o = event_q && ctrl_q.irq_en;

  always_comb begin
    bus_rdata = '0;
    unique case (widx)
      W_CNT_LO: bus_rdata = count[DATA_W-1:0];
      W_CNT_HI: bus_rdata = count[CNT_W-1:DATA_W];
      W_CTRL:   bus_rdata = {{(DATA_W-8-DIV_W){1'b0}}, ctrl_q.div, 4'b0,
                             ctrl_q.auto_inc, ctrl_q.irq_en, ctrl_q.cmp_en, ctrl_q.run};
      W_STAT:   bus_rdata = {{(DATA_W-1){1'b0}}, event_q};
      W_CMP_LO: bus_rdata = cmp_val[DATA_W-1:0];
      W_CMP_HI: bus_rdata = cmp_val[CNT_W-1:DATA_W];
      W_STEP:   bus_rdata = step_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R5: a match always leaves the event flag set
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> event_q);
  // R6: a clear write with no match drops the flag
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == W_STAT && bus_wdata[0] && !hit) |=> !event_q);
  // R5, R6: the flag only rises through a match
  p_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(event_q) |-> $past(hit));
  // R10: the stored divider only changes through a control write
  p_ctrl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && widx == W_CTRL) |=> $stable(ctrl_q));
endmodule

// File: tb/cmp_timer64_tb_top.sv
module cmp_timer64_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_word = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0, fails = 0;
  string req = "R1";
  bit done = 1'b0;

  // behavioural reference state
  longint unsigned m_cnt = 0, m_cmp = 0;
  int unsigned m_step = 0, m_pre = 0;
  bit [7:0] m_div = 0;
  bit m_run = 0, m_cen = 0, m_ien = 0, m_auto = 0, m_evt = 0;

  always #10 clk = ~clk;

  cmp_timer64 dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_step = 0; m_pre = 0; m_div = 0;
      m_run = 0; m_cen = 0; m_ien = 0; m_auto = 0; m_evt = 0;
    end else begin
      bit wr, tk, hit;
      longint unsigned n_cnt, n_cmp;
      wr  = bus_valid && bus_we;
      tk  = m_run && (m_pre == m_div);
      hit = m_run && m_cen && (m_cnt >= m_cmp);
      n_cnt = m_cnt; n_cmp = m_cmp;
      if (!m_run) begin
        if (wr && bus_word == 0) n_cnt = {m_cnt[63:32], bus_wdata};
        if (wr && bus_word == 1) n_cnt = {bus_wdata, m_cnt[31:0]};
      end else if (tk) n_cnt = m_cnt + 1;
      if (wr && bus_word == 4) n_cmp = {m_cmp[63:32], bus_wdata};
      else if (wr && bus_word == 5) n_cmp = {bus_wdata, m_cmp[31:0]};
      else if (hit && m_auto) n_cmp = m_cmp + m_step;
      if (hit) m_evt = 1;
      else if (wr && bus_word == 3 && bus_wdata[0]) m_evt = 0;
      m_pre = (!m_run || tk) ? 0 : m_pre + 1;
      if (wr && bus_word == 2) begin
        m_run = bus_wdata[0]; m_cen = bus_wdata[1]; m_ien = bus_wdata[2];
        m_auto = bus_wdata[3]; m_div = bus_wdata[15:8];
      end
      if (wr && bus_word == 6) m_step = bus_wdata;
      m_cnt = n_cnt; m_cmp = n_cmp;
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] w);
    case (w)
      3'd0: return m_cnt[31:0];
      3'd1: return m_cnt[63:32];
      3'd2: return {16'd0, m_div, 4'd0, m_auto, m_ien, m_cen, m_run};
      3'd3: return {31'd0, m_evt};
      3'd4: return m_cmp[31:0];
      3'd5: return m_cmp[63:32];
      3'd6: return m_step;
      default: return 32'd0;
    endcase
  endfunction

  // per-clock comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (bus_rdata !== m_read(bus_word)) begin
        fails++;
        $display("FAIL %s word %0d rdata actual %h expected %h", req, bus_word, bus_rdata, m_read(bus_word));
      end
      checks++;
      if (irq_o !== (m_evt && m_ien)) begin
        fails++;
        $display("FAIL R7 (%s) irq actual %b expected %b", req, irq_o, m_evt && m_ien);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic wr(input logic [2:0] w, input logic [31:0] d);
    @(posedge clk); #5;
    bus_valid = 1; bus_we = 1; bus_word = w; bus_wdata = d;
    @(posedge clk); #5;
    bus_valid = 0; bus_we = 0;
  endtask

  task automatic expect_word(input logic [2:0] w, input logic [31:0] exp, input string tag);
    bus_word = w;
    @(negedge clk);
    checks++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s word %0d actual %h expected %h", tag, w, bus_rdata, exp);
    end
    #5;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired actual running expected finished");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_clk(3);
    rst_n = 1;
    wait_clk(1);
    // R1: all words zero out of reset
    req = "R1";
    for (int w = 0; w < 8; w++) expect_word(3'(w), 32'd0, "R1");

    // R10: only bits 3:0 and 15:8 of control are kept (divider 3 here)
    req = "R10";
    wr(3'd2, 32'hABCD_03F0);
    expect_word(3'd2, 32'h0000_0300, "R10");

    // R2: running with divider 3, count grows by 1 each 4 clocks
    req = "R2";
    wr(3'd2, 32'h0000_0301);
    bus_word = 3'd0;
    wait_clk(41);
    wr(3'd2, 32'h0000_0000);
    expect_word(3'd0, 32'd10, "R2");
    wait_clk(5);
    expect_word(3'd0, 32'd10, "R2");

    // R4: counter load while stopped, ignored while running
    req = "R4";
    wr(3'd0, 32'hFFFF_FFF0);
    expect_word(3'd0, 32'hFFFF_FFF0, "R4");
    wr(3'd2, 32'h1);
    wr(3'd1, 32'h5555_5555);
    expect_word(3'd1, 32'd0, "R4");

    // R3: carry from low half reaches high half
    req = "R3";
    bus_word = 3'd1;
    wait_clk(20);
    expect_word(3'd1, 32'd1, "R3");
    wr(3'd2, 32'h0);

    // R5/R9: arm compare close ahead, interrupt masked
    req = "R5";
    wr(3'd4, 32'd40);
    wr(3'd5, 32'd1);
    wr(3'd2, 32'h3);
    bus_word = 3'd3;
    wait_clk(40);
    expect_word(3'd3, 32'd1, "R5");
    // R7: unmask, irq follows the flag
    req = "R7";
    wr(3'd2, 32'h7);
    wait_clk(2);
    // R6: clear during a standing match keeps the flag
    req = "R6";
    wr(3'd3, 32'h1);
    expect_word(3'd3, 32'd1, "R6");
    wr(3'd2, 32'h5);
    wr(3'd3, 32'h0);
    expect_word(3'd3, 32'd1, "R6");
    wr(3'd3, 32'h1);
    expect_word(3'd3, 32'd0, "R6");

    // R9: compare written while enabled is still accepted
    req = "R9";
    wr(3'd2, 32'h7);
    wr(3'd4, 32'h0000_1000);
    expect_word(3'd4, 32'h0000_1000, "R9");
    wait_clk(10);
    expect_word(3'd4, 32'h0000_1000, "R9");

    // R8: periodic events with step 7
    req = "R8";
    wr(3'd2, 32'h1);
    wr(3'd6, 32'd7);
    wr(3'd4, 32'd60);
    wr(3'd3, 32'h1);
    wr(3'd2, 32'hF);
    bus_word = 3'd4;
    for (int k = 0; k < 6; k++) begin
      wait_clk(9);
      wr(3'd3, 32'h1);
    end
    wr(3'd2, 32'h1);
    bus_word = 3'd5;
    wait_clk(3);

    // R11: word 7 is inert
    req = "R11";
    wr(3'd7, 32'hFFFF_FFFF);
    expect_word(3'd7, 32'd0, "R11");
    expect_word(3'd6, 32'd7, "R11");
    wait_clk(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule